// File: doc/BRIEF.md
# Acknowledgement Frame Octet Assembler

This block produces a complete short-range wireless acknowledgement frame of eleven octets and sends it out one octet per handshake. The frame carries no payload. A single-cycle start request captures a 16-bit frame control word and an 8-bit data sequence number. The block then streams a synchronisation header (preamble and delimiter), a one-octet PHY length header, the three-octet MAC header and a two-octet frame check sequence. The check sequence is computed while the MAC header octets are accepted downstream.

The output is a valid/ready octet stream with a last marker on the final octet. The consumer may hold ready low for any number of cycles without losing data. Start requests that arrive while a frame is being sent are dropped. The next frame can begin in the cycle after the final octet has been accepted.

Top module: `ackf_assembler`

## Requirements
- R1: While rst_n is low, and in the first cycle after its release, out_valid_o and out_last_o are 0.
- R2: A start_i pulse sampled while no frame is in progress captures fcf_i and seq_i, and out_valid_o is 1 from the next cycle on with the first octet presented.
- R3: Octets 0 to 3 of the frame (counting accepted octets from 0) are 0x00, octet 4 is the delimiter 0xA7, and octet 5 is the PHY length 0x05.
- R4: Octets 6, 7 and 8 are fcf[7:0], fcf[15:8] and the sequence number, in that order.
- R5: Octets 9 and 10 are the low byte and then the high byte of a CRC over octets 6..8. The CRC uses polynomial x^16+x^12+x^5+1 and starts from 0x0000. Octets are fed least significant bit first into a right-shifting register: each bit XORs into bit 0 of the register, and on a 1 the shifted register is XORed with 0x8408.
- R6: out_last_o is 1 only while octet 10 is presented. After that octet is accepted, out_valid_o is 0 in the next cycle.
- R7: While out_valid_o is 1 and out_ready_i is 0, the next cycle keeps out_valid_o at 1 and leaves out_data_o and out_last_o unchanged.
- R8: A start_i pulse sampled while a frame is in progress is ignored: the frame in progress completes unchanged and no further frame follows.
- R9: A start_i held high through the cycle after a final octet is accepted starts a new frame, whose CRC again starts from 0x0000. There is exactly one idle cycle between the two frames.
- R10: Changes on fcf_i and seq_i after a start has been accepted have no effect on the frame being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Request to build and send one frame |
| fcf_i | input | 16 | Frame control value captured on an accepted start |
| seq_i | input | 8 | Data sequence number captured on an accepted start |
| out_valid_o | output | 1 | Octet on out_data_o is valid |
| out_ready_i | input | 1 | Consumer accepts the current octet |
| out_data_o | output | 8 | Current frame octet |
| out_last_o | output | 1 | Current octet is the final one of the frame |

## Verification
The first octet is due one cycle after the edge that samples an accepted start. Each later octet is due one cycle after the edge at which its predecessor was accepted. The check sequence is due in the cycle after the sequence-number octet is accepted, because the CRC register takes that octet at the same edge. The bench keeps a queue of expected octets and updates it at each rising edge with the same handshake the design sees. It compares valid, data and last at the following falling edge, so every result is sampled in exactly the cycle it becomes due. Stalls and dropped starts are checked against the values held from the previous cycle and against the number of completed frames.

// File: rtl/ackf_pkg.sv
package ackf_pkg;

  localparam int ACKF_OCT_W        = 8;
  localparam int ACKF_FCF_W        = 16;
  localparam int ACKF_DSN_W        = 8;
  localparam int ACKF_FCS_W        = 16;
  localparam int ACKF_SFD_OCTETS   = 1;
  localparam int ACKF_PHR_OCTETS   = 1;
  localparam int ACKF_MHR_OCTETS   = 3;
  localparam int ACKF_FCS_OCTETS   = 2;

  // field currently being presented on the octet stream
  typedef enum logic [2:0] {
    FLD_PRE = 3'd0,
    FLD_SFD = 3'd1,
    FLD_PHR = 3'd2,
    FLD_MHR = 3'd3,
    FLD_FCS = 3'd4
  } ackf_fld_e;

  // header values captured on an accepted start
  typedef struct packed {
    logic [ACKF_FCF_W-1:0] fcf;
    logic [ACKF_DSN_W-1:0] dsn;
  } ackf_hdr_t;

endpackage

// File: rtl/ackf_seq.sv
module ackf_seq #(
  parameter int FRAME_OCTETS = 11,
  parameter int IDX_W        = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             ready_i,
  output logic             active_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             accept_o,
  output logic             fire_o,
  output logic             last_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_OCTETS - 1);

  logic             active_q, active_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             upd_en;

  assign accept_o = !active_q && start_i;
  assign fire_o   = active_q && ready_i;
  assign last_o   = active_q && (idx_q == LAST_IDX);
  assign upd_en   = accept_o || fire_o;

  always_comb begin
    active_d = active_q;
    idx_d    = idx_q;
    if (accept_o) begin
      active_d = 1'b1;
      idx_d    = '0;
    end else if (fire_o) begin
      if (idx_q == LAST_IDX) begin
        active_d = 1'b0;
        idx_d    = '0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (upd_en) begin
      active_q <= active_d;
      idx_q    <= idx_d;
    end
  end

  assign active_o = active_q;
  assign idx_o    = idx_q;

endmodule

// File: rtl/ackf_crc16.sv
module ackf_crc16 #(
  parameter int          CRC_W = 16,
  parameter int          DIN_W = 8,
  parameter logic [15:0] POLY  = 16'h8408
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [DIN_W-1:0] din_i,
  output logic [CRC_W-1:0] crc_o
);

  logic [CRC_W-1:0] crc_q, crc_d;
  logic [CRC_W-1:0] chain [0:DIN_W];

  assign chain[0] = crc_q;

  // one unrolled stage per input bit, least significant bit first
  for (genvar g = 0; g < DIN_W; g++) begin : g_bit
    logic fb;
    assign fb           = chain[g][0] ^ din_i[g];
    assign chain[g + 1] = {1'b0, chain[g][CRC_W-1:1]} ^ ({CRC_W{fb}} & CRC_W'(POLY));
  end

  always_comb begin
    crc_d = crc_q;
    if (clr_i) begin
      crc_d = '0;
    end else if (en_i) begin
      crc_d = chain[DIN_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '0;
    end else if (clr_i || en_i) begin
      crc_q <= crc_d;
    end
  end

  assign crc_o = crc_q;

endmodule

// File: rtl/ackf_octet_sel.sv
module ackf_octet_sel
  import ackf_pkg::*;
#(
  parameter int          PRE_OCTETS = 4,
  parameter logic [7:0]  SFD_VAL    = 8'hA7,
  parameter int          IDX_W      = 4
) (
  input  logic [IDX_W-1:0]      idx_i,
  input  ackf_hdr_t             hdr_i,
  input  logic [ACKF_FCS_W-1:0] crc_i,
  output ackf_fld_e             fld_o,
  output logic [ACKF_OCT_W-1:0] data_o
);

  localparam int SFD_POS  = PRE_OCTETS;
  localparam int PHR_POS  = SFD_POS + ACKF_SFD_OCTETS;
  localparam int MHR_POS  = PHR_POS + ACKF_PHR_OCTETS;
  localparam int FCS_POS  = MHR_POS + ACKF_MHR_OCTETS;
  localparam int PSDU_LEN = ACKF_MHR_OCTETS + ACKF_FCS_OCTETS;

  int unsigned pos;
  assign pos = 32'(idx_i);

  always_comb begin
    if (pos < SFD_POS) begin
      fld_o = FLD_PRE;
    end else if (pos < PHR_POS) begin
      fld_o = FLD_SFD;
    end else if (pos < MHR_POS) begin
      fld_o = FLD_PHR;
    end else if (pos < FCS_POS) begin
      fld_o = FLD_MHR;
    end else begin
      fld_o = FLD_FCS;
    end
  end

  always_comb begin
    data_o = '0;
    unique case (fld_o)
      FLD_PRE: data_o = '0;
      FLD_SFD: data_o = SFD_VAL;
      FLD_PHR: data_o = ACKF_OCT_W'(PSDU_LEN);
      FLD_MHR: begin
        if (pos == MHR_POS) begin
          data_o = hdr_i.fcf[7:0];
        end else if (pos == MHR_POS + 1) begin
          data_o = hdr_i.fcf[15:8];
        end else begin
          data_o = hdr_i.dsn;
        end
      end
      FLD_FCS: begin
        if (pos == FCS_POS) begin
          data_o = crc_i[7:0];
        end else begin
          data_o = crc_i[15:8];
        end
      end
      default: data_o = '0;
    endcase
  end

endmodule

// File: rtl/ackf_assembler.sv
module ackf_assembler
  import ackf_pkg::*;
#(
  parameter int          PRE_OCTETS = 4,
  parameter logic [7:0]  SFD_VAL    = 8'hA7,
  parameter logic [15:0] CRC_POLY   = 16'h8408
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [ACKF_FCF_W-1:0] fcf_i,
  input  logic [ACKF_DSN_W-1:0] seq_i,
  output logic                  out_valid_o,
  input  logic                  out_ready_i,
  output logic [ACKF_OCT_W-1:0] out_data_o,
  output logic                  out_last_o
);

  localparam int FRAME_OCTETS = PRE_OCTETS + ACKF_SFD_OCTETS + ACKF_PHR_OCTETS
                              + ACKF_MHR_OCTETS + ACKF_FCS_OCTETS;
  localparam int IDX_W        = $clog2(FRAME_OCTETS);

  logic                  active;
  logic [IDX_W-1:0]      idx;
  logic                  accept;
  logic                  fire;
  logic                  last;
  ackf_hdr_t             hdr_q, hdr_d;
  ackf_fld_e             fld;
  logic [ACKF_OCT_W-1:0] octet;
  logic [ACKF_FCS_W-1:0] crc;
  logic                  crc_en;

  ackf_seq #(
    .FRAME_OCTETS (FRAME_OCTETS),
    .IDX_W        (IDX_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .ready_i  (out_ready_i),
    .active_o (active),
    .idx_o    (idx),
    .accept_o (accept),
    .fire_o   (fire),
    .last_o   (last)
  );

  // header capture, enabled only by an accepted start
  always_comb begin
    hdr_d     = hdr_q;
    if (accept) begin
      hdr_d.fcf = fcf_i;
      hdr_d.dsn = seq_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q <= '0;
    end else if (accept) begin
      hdr_q <= hdr_d;
    end
  end

  ackf_octet_sel #(
    .PRE_OCTETS (PRE_OCTETS),
    .SFD_VAL    (SFD_VAL),
    .IDX_W      (IDX_W)
  ) u_sel (
    .idx_i  (idx),
    .hdr_i  (hdr_q),
    .crc_i  (crc),
    .fld_o  (fld),
    .data_o (octet)
  );

  assign crc_en = fire && (fld == FLD_MHR);

  ackf_crc16 #(
    .CRC_W (ACKF_FCS_W),
    .DIN_W (ACKF_OCT_W),
    .POLY  (CRC_POLY)
  ) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (accept),
    .en_i  (crc_en),
    .din_i (octet),
    .crc_o (crc)
  );

  assign out_valid_o = active;
  assign out_data_o  = octet;
  assign out_last_o  = last;

endmodule

// File: rtl/ackf_chk.sv
module ackf_chk #(
  parameter int         PRE_OCTETS = 4,
  parameter logic [7:0] SFD_VAL    = 8'hA7
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       out_valid_o,
  input logic       out_ready_i,
  input logic [7:0] out_data_o,
  input logic       out_last_o
);

  localparam int FRAME_OCTETS = PRE_OCTETS + 7;
  localparam int BW           = $clog2(FRAME_OCTETS + 1);

  // counts accepted octets of the current frame, independent of the design
  logic [BW-1:0] beat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat <= '0;
    end else if (out_valid_o && out_ready_i) begin
      if (out_last_o) begin
        beat <= '0;
      end else begin
        beat <= beat + 1'b1;
      end
    end
  end

  p_start_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid_o && start_i |=> out_valid_o);

  p_preamble_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && (beat < BW'(PRE_OCTETS)) |-> out_data_o == 8'h00);

  p_delim_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && (beat == BW'(PRE_OCTETS)) |-> out_data_o == SFD_VAL);

  p_length_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && (beat == BW'(PRE_OCTETS + 1)) |-> out_data_o == 8'h05);

  p_last_pos_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && out_last_o |-> beat == BW'(FRAME_OCTETS - 1));

  p_end_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && out_ready_i && out_last_o |=> !out_valid_o);

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_last_o));

endmodule

bind ackf_assembler ackf_chk #(
  .PRE_OCTETS (PRE_OCTETS),
  .SFD_VAL    (SFD_VAL)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .out_last_o  (out_last_o)
);

// File: tb/tb_ackf_assembler.sv
module tb_ackf_assembler;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [15:0] fcf_i;
  logic [7:0]  seq_i;
  logic        out_valid_o;
  logic        out_ready_i;
  logic [7:0]  out_data_o;
  logic        out_last_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int frames_done = 0;
  string scen = "R1";

  logic [7:0] q[$];
  logic       prev_stall;
  logic [7:0] prev_data;
  logic       prev_last;

  ackf_assembler dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .fcf_i       (fcf_i),
    .seq_i       (seq_i),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_data_o  (out_data_o),
    .out_last_o  (out_last_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [15:0] fcs_of(input logic [15:0] f, input logic [7:0] s);
    logic [15:0] r;
    logic [7:0]  oc [3];
    oc[0] = f[7:0];
    oc[1] = f[15:8];
    oc[2] = s;
    r = 16'h0000;
    for (int k = 0; k < 3; k++) begin
      for (int b = 0; b < 8; b++) begin
        logic fbit;
        fbit = r[0] ^ oc[k][b];
        r = r >> 1;
        if (fbit) r = r ^ 16'h8408;
      end
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: queue of expected octets
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
    end else if (q.size() > 0) begin
      if (out_ready_i) begin
        void'(q.pop_front());
        if (q.size() == 0) frames_done++;
      end
    end else if (start_i) begin
      logic [15:0] c;
      c = fcs_of(fcf_i, seq_i);
      for (int k = 0; k < 4; k++) q.push_back(8'h00);
      q.push_back(8'hA7);
      q.push_back(8'h05);
      q.push_back(fcf_i[7:0]);
      q.push_back(fcf_i[15:8]);
      q.push_back(seq_i);
      q.push_back(c[7:0]);
      q.push_back(c[15:8]);
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit   ev;
      int   pos;
      string ft;
      ev = (q.size() > 0);
      check(out_valid_o == ev, {scen, "/R2 valid"}, int'(out_valid_o), int'(ev));
      if (ev) begin
        pos = 11 - q.size();
        ft = (pos < 6) ? "R3" : (pos < 9) ? "R4" : "R5";
        check(out_data_o == q[0], {scen, "/", ft, " data"}, int'(out_data_o), int'(q[0]));
        check(out_last_o == (q.size() == 1), {scen, "/R6 last"}, int'(out_last_o), int'(q.size() == 1));
      end else begin
        check(out_last_o == 1'b0, {scen, "/R6 last idle"}, int'(out_last_o), 0);
      end
      if (prev_stall) begin
        check(out_valid_o && out_data_o == prev_data && out_last_o == prev_last,
              {scen, "/R7 hold"}, int'(out_data_o), int'(prev_data));
      end
      prev_stall = out_valid_o && !out_ready_i;
      prev_data  = out_data_o;
      prev_last  = out_last_o;
    end else begin
      prev_stall = 1'b0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected<=50000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // mode: 0 ready high, 1 random ready; noise: 0 none, 1 start pulses, 2 header changes
  task automatic run_frame(input logic [15:0] f, input logic [7:0] s, input int mode, input int noise);
    int n;
    @(negedge clk);
    start_i     = 1'b1;
    fcf_i       = f;
    seq_i       = s;
    out_ready_i = (mode == 0) ? 1'b1 : 1'($urandom_range(0, 1));
    @(negedge clk);
    start_i = 1'b0;
    n = 0;
    while (q.size() > 0 && n < 400) begin
      out_ready_i = (mode == 0) ? 1'b1 : 1'($urandom_range(0, 1));
      if (noise == 1) begin
        start_i = 1'($urandom_range(0, 1));
        fcf_i   = 16'($urandom);
      end else if (noise == 2) begin
        fcf_i = 16'($urandom);
        seq_i = 8'($urandom);
      end
      @(negedge clk);
      start_i = 1'b0;
      n++;
    end
    start_i = 1'b0;
  endtask

  initial begin
    int fd;
    rst_n       = 1'b0;
    start_i     = 1'b0;
    fcf_i       = 16'h0;
    seq_i       = 8'h0;
    out_ready_i = 1'b0;
    prev_stall  = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid_o == 1'b0, "R1 valid in reset", int'(out_valid_o), 0);
    check(out_last_o == 1'b0, "R1 last in reset", int'(out_last_o), 0);
    start_i = 1'b1;
    @(negedge clk);
    check(out_valid_o == 1'b0, "R1 start ignored in reset", int'(out_valid_o), 0);
    start_i = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid_o == 1'b0 && out_last_o == 1'b0, "R1 after release", int'(out_valid_o), 0);

    scen = "R2";
    fd = frames_done;
    run_frame(16'h0002, 8'h5A, 0, 0);
    check(frames_done == fd + 1, "R2 frame count", frames_done - fd, 1);

    scen = "R5";
    run_frame(16'hFFFF, 8'hFF, 0, 0);
    run_frame(16'h0000, 8'h00, 0, 0);
    run_frame(16'h1234, 8'h80, 0, 0);

    scen = "R7";
    for (int i = 0; i < 4; i++) run_frame(16'($urandom), 8'($urandom), 1, 0);

    scen = "R8";
    fd = frames_done;
    run_frame(16'hA55A, 8'h3C, 1, 1);
    repeat (3) @(negedge clk);
    check(frames_done == fd + 1, "R8 single frame despite starts", frames_done - fd, 1);
    check(out_valid_o == 1'b0, "R8 no extra frame", int'(out_valid_o), 0);

    scen = "R10";
    fd = frames_done;
    run_frame(16'h0C0F, 8'h11, 1, 2);
    check(frames_done == fd + 1, "R10 frame count", frames_done - fd, 1);

    scen = "R9";
    fd = frames_done;
    @(negedge clk);
    fcf_i       = 16'h4242;
    seq_i       = 8'h07;
    out_ready_i = 1'b1;
    start_i     = 1'b1;
    repeat (36) @(negedge clk);
    start_i = 1'b0;
    repeat (14) @(negedge clk);
    check(frames_done == fd + 3, "R9 back-to-back frames", frames_done - fd, 3);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule